// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Controller

This block gathers ten completion and error events from a DMA bridge and keeps them in one 32-bit control/status word. Two events belong to a USB data path: transfer finished and address fault. The other eight belong to two audio channels. Each channel has a playback direction and a record direction, and each direction reports both half-buffer and full-buffer completion. Every event has its own sticky status flag and its own enable flag.

The block folds the enabled, pending events onto three registered, active-high interrupt levels:

- The USB address fault has a line to itself.
- USB transfer completion shares a line with the four audio full-buffer events.
- The four audio half-buffer events share the third line.

Software reads the whole word in one access. It acknowledges an event by writing 0 to that event's status flag, and it masks an event by writing 0 to that event's enable flag. Writing 1 to a status flag changes nothing. This lets software update enables with a read-modify-write without touching pending events.

Top module: `dma_evt_irq_ctl`

## Requirements
- R1: A write stores the event enables from `wr_data`. The eight audio enables sit in bits 31:24: event id n (2..9) uses bit n+22. The two USB enables sit in bits 9:8: event id n (0..1) uses bit n+8. Event ids are 0 = USB done, 1 = USB address fault, and 2..9 = audio events. The audio order is: channel 0 playback full, channel 0 playback half, channel 0 record full, channel 0 record half, then the same four for channel 1.
- R2: A one-cycle pulse on `evt_pulse[n]` sets the status flag of event n. For n = 0..1 the flag is bit n; for n = 2..9 it is bit n+14. The flag is set even when the event is masked, and it is visible on `rd_data` after that clock edge.
- R3: Writing 0 to a status bit clears it. Writing 1 to a status bit neither sets a cleared flag nor disturbs a set one.
- R4: An event pulse in the same cycle as a write of 0 to its status bit leaves the flag set.
- R5: Bits 15:10 and 7:2 always read 0, whatever is written.
- R6: `irq[0]` is driven only by event 1 (USB address fault) when its status and enable bits are both 1.
- R7: `irq[1]` is driven by event 0 and by the audio full-buffer events (ids 2, 4, 6, 8), each gated by its own enable.
- R8: `irq[2]` is driven by the audio half-buffer events (ids 3, 5, 7, 9), each gated by its own enable.
- R9: The interrupt outputs are registered. A line changes one clock after the status/enable state that drives it changes, and it drops after an acknowledge or a mask.
- R10: Reset clears all flags and lowers all lines. A write of all zeros with no event pulse clears every enable and status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| evt_pulse | input | 10 | Single-cycle event inputs, indexed by event id |
| irq | output | 3 | Interrupt levels: [0] address fault, [1] full/done, [2] half |

## Verification
The properties assume that each event input is a single-cycle pulse sampled on the clock. They also assume that `wr_data` is meaningful only while `wr_en` is high, and that nothing happens until the internal reset has been released. The directed stimulus drives all inputs just after a rising edge and holds each one for exactly one cycle. It waits several cycles after `rst_n` goes high before the first access, so the internal reset has been released. Collisions between an event and a clearing write are created on purpose, and only in the scenario that targets them.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_USB   = 2;
  localparam int NUM_AUDIO = 8;
  localparam int NUM_EVT   = NUM_USB + NUM_AUDIO;
  localparam int NUM_LINE  = 3;
  localparam int AUD_EN_LSB  = 24;
  localparam int AUD_ST_LSB  = 16;
  localparam int USB_EN_LSB  = 8;
  localparam int USB_ST_LSB  = 0;

  typedef enum logic [1:0] {
    LINE_FAULT = 2'd0,
    LINE_FULL  = 2'd1,
    LINE_HALF  = 2'd2
  } irq_line_e;

  // bit position of the enable flag of an event id
  function automatic int en_pos(input int id);
    if (id < NUM_USB) return USB_EN_LSB + id;
    return AUD_EN_LSB + (id - NUM_USB);
  endfunction

  // bit position of the status flag of an event id
  function automatic int st_pos(input int id);
    if (id < NUM_USB) return USB_ST_LSB + id;
    return AUD_ST_LSB + (id - NUM_USB);
  endfunction

  // interrupt line an event id folds onto
  function automatic int line_of(input int id);
    if (id == 1) return int'(LINE_FAULT);
    if (id == 0) return int'(LINE_FULL);
    if (((id - NUM_USB) % 2) == 0) return int'(LINE_FULL);
    return int'(LINE_HALF);
  endfunction
endpackage

// File: rtl/dma_evt_rst_sync.sv
module dma_evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_evt_flag_cell.sv
module dma_evt_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_st_bit,
  input  logic evt,
  output logic en_q,
  output logic st_q,
  output logic pend
);
  logic en_d, st_d;
  logic en_ce, st_ce;

  always_comb begin
    en_ce = wr_en;
    en_d  = wr_en_bit;
    // event has priority; a written 0 clears, a written 1 is ignored
    st_ce = evt | (wr_en & ~wr_st_bit);
    st_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 1'b0;
    else if (st_ce) st_q <= st_d;
  end

  assign pend = en_q & st_q;
endmodule

// File: rtl/dma_evt_irq_router.sv
module dma_evt_irq_router
  import dma_evt_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int N_LINE = NUM_LINE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  pend,
  output logic [N_LINE-1:0] irq_q
);
  logic [N_LINE-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int l = 0; l < N_LINE; l++) begin
      for (int i = 0; i < N_EVT; i++) begin
        if (line_of(i) == l) irq_d[l] = irq_d[l] | pend[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/dma_evt_irq_ctl.sv
module dma_evt_irq_ctl
  import dma_evt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  output logic [NUM_LINE-1:0] irq
);
  logic               srst_n;
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] st_q;
  logic [NUM_EVT-1:0] pend;

  dma_evt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cell
    localparam int EP = en_pos(g);
    localparam int SP = st_pos(g);
    dma_evt_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_en     (wr_en),
      .wr_en_bit (wr_data[EP]),
      .wr_st_bit (wr_data[SP]),
      .evt       (evt_pulse[g]),
      .en_q      (en_q[g]),
      .st_q      (st_q[g]),
      .pend      (pend[g])
    );
  end

  dma_evt_irq_router #(.N_EVT(NUM_EVT), .N_LINE(NUM_LINE)) u_route (
    .clk   (clk),
    .rst_n (srst_n),
    .pend  (pend),
    .irq_q (irq)
  );

  // reserved positions stay 0
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      rd_data[en_pos(i)] = en_q[i];
      rd_data[st_pos(i)] = st_q[i];
    end
  end
endmodule

// File: rtl/dma_evt_irq_ctl_chk.sv
module dma_evt_irq_ctl_chk
  import dma_evt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [REG_W-1:0]    wr_data,
  input logic [REG_W-1:0]    rd_data,
  input logic [NUM_EVT-1:0]  evt_pulse,
  input logic [NUM_LINE-1:0] irq
);
  logic [7:0] aud_pend;
  assign aud_pend = rd_data[31:24] & rd_data[23:16];

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:10] == 6'd0) && (rd_data[7:2] == 6'd0));

  // R2
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_set
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[g] |=> rd_data[st_pos(g)]);
  end

  // R3
  one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !evt_pulse[0] && !rd_data[0]) |=> !rd_data[0]);

  // R4
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[16] && evt_pulse[2]) |=> rd_data[16]);

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0 && evt_pulse == '0) |=> rd_data == '0);

  // R6
  line_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> $past(rd_data[1] && rd_data[9]));

  // R7
  line_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> $past((rd_data[0] && rd_data[8]) || |(aud_pend & 8'h55)));

  // R8
  line_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[2] |-> $past(|(aud_pend & 8'hAA)));

  // R9
  line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && rd_data[9]) |=> irq[0]);
endmodule

bind dma_evt_irq_ctl dma_evt_irq_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .evt_pulse (evt_pulse),
  .irq       (irq)
);

// File: tb/dma_evt_irq_ctl_test.sv
module dma_evt_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [9:0]  evt_pulse;
  logic [2:0]  irq;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_evt_irq_ctl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  // positions taken from the requirements (R1, R2)
  function automatic int ebit(input int id);
    return (id < 2) ? id + 8 : id + 22;
  endfunction
  function automatic int sbit(input int id);
    return (id < 2) ? id : id + 14;
  endfunction
  // routing from R6, R7, R8
  function automatic logic [2:0] line_mask(input int id);
    if (id == 1) return 3'b001;
    if (id == 0) return 3'b010;
    if (id == 2 || id == 4 || id == 6 || id == 8) return 3'b010;
    return 3'b100;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [9:0] m);
    evt_pulse = m;
    cyc();
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    chk("R10 reset word", rd_data, 32'h0);
    chk("R10 reset irq", {29'd0, irq}, 32'h0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    chk("R1/R5 enable layout", rd_data, 32'hFF00_0300);
    wr(32'h0);
    chk("R10 zero write clears", rd_data, 32'h0);
  endtask

  task automatic t_masked();
    pulse(10'h3FF);
    chk("R2 masked events latch", rd_data, 32'h00FF_0003);
    cyc();
    chk("R2 masked no irq", {29'd0, irq}, 32'h0);
    wr(32'h0);
    chk("R3 zero clears status", rd_data, 32'h0);
  endtask

  task automatic t_route();
    for (int id = 0; id < 10; id++) begin
      wr(32'h1 << ebit(id));
      pulse(10'h1 << id);
      chk("R2 status set", rd_data, (32'h1 << ebit(id)) | (32'h1 << sbit(id)));
      chk("R9 irq not yet", {29'd0, irq}, 32'h0);
      cyc();
      chk("R6/R7/R8 routing", {29'd0, irq}, {29'd0, line_mask(id)});
      wr(32'h1 << ebit(id));
      cyc();
      chk("R9 ack drops irq", {29'd0, irq}, 32'h0);
    end
    wr(32'h0);
  endtask

  task automatic t_write_one();
    wr(32'h00FF_0003);
    chk("R3 write one no set", rd_data, 32'h0);
    pulse(10'h1 << 3);
    wr(32'hFFFF_FFFF);
    chk("R3 write one keeps", rd_data, 32'hFF00_0300 | (32'h1 << sbit(3)));
    cyc();
    chk("R8 half line", {29'd0, irq}, 32'h4);
    wr(32'hFF00_0300);
    chk("R3 ack one", rd_data, 32'hFF00_0300);
    cyc();
    chk("R9 ack drop", {29'd0, irq}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_collide();
    pulse(10'h1 << 5);
    wr_en = 1'b1; wr_data = 32'h0; evt_pulse = 10'h1 << 5;
    cyc();
    wr_en = 1'b0; evt_pulse = '0;
    chk("R4 event beats clear", rd_data, 32'h1 << sbit(5));
    wr(32'h0);
  endtask

  task automatic t_mask();
    wr(32'h8000_0000);
    pulse(10'h1 << 9);
    cyc();
    chk("R8 id9 line", {29'd0, irq}, 32'h4);
    wr(32'h0080_0000);
    chk("R1 mask keeps status", rd_data, 32'h0080_0000);
    cyc();
    chk("R9 mask drops irq", {29'd0, irq}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_multi();
    wr(32'hFF00_0300);
    pulse(10'b00_0000_1101);
    chk("R2 multi status", rd_data, 32'hFF03_0301);
    cyc();
    chk("R7/R8 multi lines", {29'd0, irq}, 32'h6);
    wr(32'h0);
    cyc();
    chk("R10 clear all irq", {29'd0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; evt_pulse = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_layout();
    t_masked();
    t_route();
    t_write_one();
    t_collide();
    t_mask();
    t_multi();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule